// File: doc/BRIEF.md
# Sixty-Bit Shift and Mask Unit

This unit produces the result of a family of 60-bit operations: a left shift and a sign-filling right shift whose count is a 6-bit immediate, the same two shifts with a count taken from an 18-bit index value, and a mask builder that sets a chosen number of the most significant bits. A caller presents an opcode, the immediate, the index value and the 60-bit operand together with a one-cycle strobe. The registered result appears on the next clock edge.

The count handling has several end cases. A left count of 60 clears the word, and counts above 60 wrap around to short left shifts. A right count of 59 or more leaves only copies of the sign bit. The index value is taken as an 18-bit one's-complement number. When it is negative, the shift direction is reversed and the count becomes its magnitude. When it is large, a right shift returns zero.

Top module: `shift_mask_unit`

## Requirements
- R1: `valid_o` and `result_o` update on the first rising clock edge after `valid_i` is sampled high. `valid_o` is low on the edge after a cycle with `valid_i` low, and `result_o` keeps its value on that edge.
- R2: While `rst_ni` is low, `valid_o` and `result_o` are zero.
- R3: With opcode 6'o20 and immediate count c below 60, the result is the operand shifted left by c, with zeros filling from the bottom.
- R4: With opcode 6'o20, a count of 60 gives zero, and counts 61, 62 and 63 give left shifts of 1, 2 and 3.
- R5: With opcode 6'o21, the result is the operand shifted right by the count, with copies of bit 59 filling from the top. A count of 59 or more gives sixty copies of bit 59.
- R6: With opcodes 6'o22 and 6'o23 and bit 17 of `bval_i` clear, the count is `bval_i[5:0]`, and the results match opcodes 6'o20 and 6'o21. The exception: 6'o23 returns zero when `bval_i` exceeds 63. For 6'o22, bits 17:6 are ignored.
- R7: With bit 17 of `bval_i` set, the magnitude is `~bval_i`. Opcode 6'o22 then applies the 6'o23 rules to this magnitude, so a magnitude above 63 gives zero. Opcode 6'o23 then applies the 6'o20 rules to the magnitude's low 6 bits.
- R8: Opcode 6'o43 sets the top `imm_i` bits of the result and clears the rest. A count of 0 gives all zeros, and a count of 60 or more gives all ones.
- R9: Any other opcode yields a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 6 | Opcode |
| imm_i | input | 6 | Immediate count |
| bval_i | input | 18 | Index value used as a signed count |
| xop_i | input | 60 | Operand |
| valid_o | output | 1 | Result valid |
| result_o | output | 60 | Registered result |

## Verification
Every result is due exactly one clock edge after the strobe is sampled. The bench drives inputs on the falling edge and raises the strobe for a single cycle. It then reads `valid_o` and `result_o` on the following falling edge, which is half a period after the edge that registers the result. Idle cycles between operations check that `valid_o` drops on the next edge and that `result_o` does not change.

// File: rtl/smu_pkg.sv
package smu_pkg;
  localparam int OP_W = 6;
  typedef enum logic [OP_W-1:0] {
    OP_SHL_IMM = 6'o20,
    OP_SAR_IMM = 6'o21,
    OP_SHL_B   = 6'o22,
    OP_SAR_B   = 6'o23,
    OP_MASK    = 6'o43
  } smu_op_e;
endpackage

// File: rtl/smu_count_decode.sv
module smu_count_decode
  import smu_pkg::*;
#(
  parameter int DATA_W = 60,
  parameter int CNT_W  = 6,
  parameter int B_W    = 18
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [CNT_W-1:0] imm_i,
  input  logic [B_W-1:0]   bval_i,
  output logic             go_left_o,
  output logic [CNT_W-1:0] amt_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] LIM    = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(DATA_W - 1);

  logic             b_neg;
  logic [B_W-1:0]   mag;
  logic [CNT_W-1:0] cnt;
  logic             big;
  logic             known;
  logic             wrap_zero;

  always_comb begin
    b_neg     = bval_i[B_W-1];
    mag       = b_neg ? ~bval_i : bval_i;   // one's-complement magnitude
    go_left_o = 1'b1;
    cnt       = imm_i;
    big       = 1'b0;
    known     = 1'b1;
    case (op_i)
      OP_SHL_IMM: go_left_o = 1'b1;
      OP_SAR_IMM: go_left_o = 1'b0;
      OP_SHL_B: begin
        go_left_o = !b_neg;
        cnt       = mag[CNT_W-1:0];
        big       = b_neg && (|mag[B_W-1:CNT_W]);
      end
      OP_SAR_B: begin
        go_left_o = b_neg;
        cnt       = mag[CNT_W-1:0];
        big       = !b_neg && (|mag[B_W-1:CNT_W]);
      end
      default: known = 1'b0;
    endcase

    wrap_zero = 1'b0;
    if (go_left_o) begin
      if (cnt < LIM)       amt_o = cnt;
      else if (cnt == LIM) begin amt_o = '0; wrap_zero = 1'b1; end
      else                 amt_o = cnt - LIM;
    end else begin
      amt_o = (cnt >= LIM_M1) ? LIM_M1 : cnt;  // full sign fill
    end
    zero_o = !known || big || wrap_zero;
  end
endmodule

// File: rtl/smu_barrel.sv
module smu_barrel #(
  parameter int DATA_W = 60,
  parameter int CNT_W  = 6,
  parameter bit LEFT   = 1'b1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] stage [CNT_W+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    if (LEFT) begin : g_l
      assign stage[k+1] = amt_i[k] ? (stage[k] << STEP) : stage[k];
    end else begin : g_r
      assign stage[k+1] = amt_i[k] ? DATA_W'($signed(stage[k]) >>> STEP) : stage[k];
    end
  end

  assign data_o = stage[CNT_W];
endmodule

// File: rtl/smu_mask_gen.sv
module smu_mask_gen #(
  parameter int DATA_W = 60,
  parameter int CNT_W  = 6
) (
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign mask_o[DATA_W-1-i] = (CNT_W'(i) < cnt_i);
  end
endmodule

// File: rtl/shift_mask_unit.sv
module shift_mask_unit
  import smu_pkg::*;
#(
  parameter int DATA_W = 60,
  parameter int CNT_W  = 6,
  parameter int B_W    = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [5:0]        op_i,
  input  logic [CNT_W-1:0]  imm_i,
  input  logic [B_W-1:0]    bval_i,
  input  logic [DATA_W-1:0] xop_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  logic              go_left;
  logic [CNT_W-1:0]  amt;
  logic              zero_res;
  logic [DATA_W-1:0] shl_res;
  logic [DATA_W-1:0] sar_res;
  logic [DATA_W-1:0] mask_res;
  logic [DATA_W-1:0] result_d;

  smu_count_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W), .B_W(B_W)) u_dec (
    .op_i     (op_i),
    .imm_i    (imm_i),
    .bval_i   (bval_i),
    .go_left_o(go_left),
    .amt_o    (amt),
    .zero_o   (zero_res)
  );

  smu_barrel #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEFT(1'b1)) u_shl (
    .data_i(xop_i), .amt_i(amt), .data_o(shl_res)
  );

  smu_barrel #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEFT(1'b0)) u_sar (
    .data_i(xop_i), .amt_i(amt), .data_o(sar_res)
  );

  smu_mask_gen #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_mask (
    .cnt_i(imm_i), .mask_o(mask_res)
  );

  always_comb begin
    if (op_i == OP_MASK) result_d = mask_res;
    else if (zero_res)   result_d = '0;
    else if (go_left)    result_d = shl_res;
    else                 result_d = sar_res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= result_d;
    end
  end
endmodule

// File: rtl/smu_checks.sv
module smu_checks #(
  parameter int DATA_W = 60,
  parameter int CNT_W  = 6,
  parameter int B_W    = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [5:0]        op_i,
  input logic [CNT_W-1:0]  imm_i,
  input logic [B_W-1:0]    bval_i,
  input logic [DATA_W-1:0] xop_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r1_result_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  a_r4_shl_sixty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 6'o20 && imm_i == 6'd60) |=> (result_o == '0));
  a_r5_sign_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 6'o21 && imm_i >= 6'd59) |=> (result_o == {DATA_W{$past(xop_i[DATA_W-1])}}));
  a_r6_big_right_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 6'o23 && !bval_i[B_W-1] && (|bval_i[B_W-2:CNT_W])) |=> (result_o == '0));
  a_r8_mask_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 6'o43 && imm_i == '0) |=> (result_o == '0));
  a_r8_mask_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 6'o43 && imm_i >= 6'd60) |=> (result_o == '1));
  a_r9_unknown_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 6'o24) |=> (result_o == '0));
endmodule

bind shift_mask_unit smu_checks #(.DATA_W(DATA_W), .CNT_W(CNT_W), .B_W(B_W)) u_checks (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .imm_i   (imm_i),
  .bval_i  (bval_i),
  .xop_i   (xop_i),
  .valid_o (valid_o),
  .result_o(result_o)
);

// File: tb/shift_mask_unit_test.sv
module shift_mask_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [5:0]  op = '0;
  logic [5:0]  imm = '0;
  logic [17:0] bval = '0;
  logic [59:0] xop = '0;
  logic        valid_o;
  logic [59:0] result_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  shift_mask_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .imm_i(imm),
    .bval_i(bval), .xop_i(xop), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [59:0] ref_shl(input logic [59:0] x, input int c);
    if (c < 60)       return x << c;
    else if (c == 60) return '0;
    else              return x << (c - 60);
  endfunction

  function automatic logic [59:0] ref_sar(input logic [59:0] x, input int c);
    logic [59:0] r;
    if (c >= 59) return {60{x[59]}};
    r = x >> c;
    for (int i = 0; i < c; i++) r[59-i] = x[59];
    return r;
  endfunction

  function automatic logic [59:0] ref_calc(input logic [5:0] o, input logic [5:0] im,
                                           input logic [17:0] b, input logic [59:0] x);
    logic [17:0] m;
    logic [59:0] r;
    m = b[17] ? ~b : b;
    case (o)
      6'o20: return ref_shl(x, int'(im));
      6'o21: return ref_sar(x, int'(im));
      6'o22: begin
        if (!b[17]) return ref_shl(x, int'(b[5:0]));
        if (m > 18'd63) return '0;
        return ref_sar(x, int'(m));
      end
      6'o23: begin
        if (b[17]) return ref_shl(x, int'(m[5:0]));
        if (b > 18'd63) return '0;
        return ref_sar(x, int'(b));
      end
      6'o43: begin
        r = '0;
        for (int i = 0; i < 60; i++) if (i < int'(im)) r[59-i] = 1'b1;
        return r;
      end
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [59:0] act, input logic [59:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [5:0] o, input logic [5:0] im,
                        input logic [17:0] b, input logic [59:0] x);
    logic [59:0] exp;
    exp = ref_calc(o, im, b, x);
    @(negedge clk);
    op = o; imm = im; bval = b; xop = x; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check({tag, " R1 valid"}, {59'd0, valid_o}, 60'd1);
    check(tag, result_o, exp);
  endtask

  logic [59:0] pats [3];

  initial begin
    pats[0] = 60'h9A5_0F0F_1234_5678;
    pats[1] = 60'h2C3_4567_89AB_CDEF;
    pats[2] = 60'hFFF_FFFF_FFFF_FFFF;

    #(CLK_PERIOD * 2);
    check("R2 reset valid", {59'd0, valid_o}, 60'd0);
    check("R2 reset result", result_o, 60'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 64; c++) begin
        run_op(c < 60 ? "R3 shl imm" : "R4 shl wrap", 6'o20, 6'(c), 18'd0, pats[p]);
        run_op("R5 sar imm", 6'o21, 6'(c), 18'd0, pats[p]);
        run_op("R6 shl b pos", 6'o22, 6'd0, 18'(c), pats[p]);
        run_op("R6 sar b pos", 6'o23, 6'd0, 18'(c), pats[p]);
        run_op("R7 shl b neg", 6'o22, 6'd0, ~18'(c), pats[p]);
        run_op("R7 sar b neg", 6'o23, 6'd0, ~18'(c), pats[p]);
      end
      run_op("R6 sar b big", 6'o23, 6'd0, 18'd64, pats[p]);
      run_op("R6 sar b max", 6'o23, 6'd0, 18'h1FFFF, pats[p]);
      run_op("R6 shl b high bits ignored", 6'o22, 6'd0, 18'h00045, pats[p]);
      run_op("R7 shl b neg big", 6'o22, 6'd0, ~18'd64, pats[p]);
      run_op("R7 shl b neg max", 6'o22, 6'd0, 18'h20000, pats[p]);
      run_op("R7 sar b neg wrap", 6'o23, 6'd0, 18'h20000, pats[p]);
      run_op("R9 unknown op", 6'o24, 6'd5, 18'd3, pats[p]);
      run_op("R9 unknown op", 6'o00, 6'd0, 18'd0, pats[p]);
    end

    for (int c = 0; c < 64; c++) run_op("R8 mask", 6'o43, 6'(c), 18'd0, pats[c % 3]);

    // R1: idle cycles drop valid and keep the result
    run_op("R3 shl imm", 6'o20, 6'd4, 18'd0, pats[1]);
    begin
      logic [59:0] held;
      held = result_o;
      op = 6'o43; imm = 6'd60; xop = '0;
      repeat (3) begin
        @(negedge clk);
        check("R1 idle valid", {59'd0, valid_o}, 60'd0);
        check("R1 idle hold", result_o, held);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule